// File: doc/BRIEF.md
# Dual-Mode Serial Bit-Timing Generator

This block produces the bit timing for a serial port that runs either as an asynchronous UART or as a clock-synchronous shift link. A free-running prescaler supplies a base rate of the system clock divided by 1, 8 or 32. An 8-bit reloadable counter then divides that rate by (n+1). In asynchronous mode the counter pulses serve as a 16x oversampling enable. A 4-bit phase counter turns them into one transmit enable and one mid-bit receive enable per bit. A restart input realigns the phase to a detected start edge.

In synchronous mode with the internal source, each counter pulse toggles a shift-clock level. That level is driven onto the clock pin, so the pin period is 2(n+1) base periods. With the external source, the clock pin is sampled through a two-flop synchronizer and its edges become the enables directly, so the counter plays no part. A polarity control inverts the pin in both directions. A separate handshake pin works as an active-low clear-to-send input, as an active-low ready-to-receive output, or is disabled. When it is disabled, the internal clear-to-send flag is held at the permissive level. Every timing output is a single-cycle enable in the system clock domain.

Top module: `serial_clk_gen`

## Requirements
- R1: With prescale select 0 (divide by 1) in asynchronous mode (sync_mode_i=0), os_en_o pulses every n+1 cycles and tx_en_o pulses every 16(n+1) cycles, where n is divisor_i. Every tx_en_o pulse coincides with an os_en_o pulse.
- R2: Prescale select 1 gives an os_en_o interval of 8(n+1) cycles. Select 2 (and 3) gives 32(n+1) cycles.
- R3: After a one-cycle restart_i pulse, no os_en_o appears in the following cycle. rx_en_o then first pulses together with the 8th os_en_o pulse, and tx_en_o first pulses together with the 16th.
- R4: A change of divisor_i or presc_sel_i takes effect only at the next counter reload, so the period already running keeps its old length.
- R5: In synchronous mode with the internal source (sync_mode_i=1, ext_clk_i=0), sclk_oe_o is 1 and sclk_o toggles every n+1 base periods. rx_en_o marks each change to the active level and tx_en_o each change to the inactive level. tx_en_o and rx_en_o never pulse in the same cycle.
- R6: With sync_run_i low, the internally driven clock finishes its active half and then rests at the inactive level, with no tx_en_o or rx_en_o pulses.
- R7: clk_inv_i=1 makes the inactive pin level 1 and swaps which external pin edge yields tx_en_o or rx_en_o. clk_inv_i=0 makes the inactive level 0.
- R8: With the external source (sync_mode_i=1, ext_clk_i=1), sclk_oe_o is 0. Each edge on sclk_i gives exactly one enable within 3 to 4 cycles: rx_en_o for a change to the active level, tx_en_o for a change to the inactive level. A static pin gives none.
- R9: In asynchronous mode, sclk_oe_o is 0 and sclk_o stays at clk_inv_i. In synchronous mode, os_en_o stays 0.
- R10: hs_mode_i encodes 0 or 3 as disabled, 1 as CTS input and 2 as RTS output. When disabled, cts_ok_o=1 and hs_oe_o=0. In CTS mode, cts_ok_o is the inverse of the synchronized hs_i. In RTS mode, hs_oe_o=1, hs_o is the inverse of rx_ready_i, and cts_ok_o=1.
- R11: During reset, all enables are 0, sclk_oe_o is 0 and sclk_o equals clk_inv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 2 | Base rate: 0 /1, 1 /8, 2 or 3 /32 |
| divisor_i | input | 8 | Divisor value n, period n+1 |
| sync_mode_i | input | 1 | 1 clock-synchronous, 0 asynchronous |
| ext_clk_i | input | 1 | 1 takes the shift clock from sclk_i |
| clk_inv_i | input | 1 | Inverts the clock pin in both directions |
| sync_run_i | input | 1 | Lets the internal shift clock run |
| restart_i | input | 1 | Realigns counter and 16x phase |
| sclk_i | input | 1 | Clock pin input |
| sclk_o | output | 1 | Clock pin output level |
| sclk_oe_o | output | 1 | Clock pin output enable |
| hs_mode_i | input | 2 | Handshake pin function |
| hs_i | input | 1 | Handshake pin input, CTS active low |
| rx_ready_i | input | 1 | Receiver ready, drives RTS |
| hs_o | output | 1 | Handshake pin output, active low |
| hs_oe_o | output | 1 | Handshake pin output enable |
| cts_ok_o | output | 1 | Transmission allowed |
| tx_en_o | output | 1 | Transmit shift/bit enable |
| rx_en_o | output | 1 | Receive sample enable |
| os_en_o | output | 1 | 16x oversampling enable |

## Verification
Random prescale and divisor pairs in asynchronous mode tell apart the three base rates and the (n+1) division. A directed divisor change in mid-period separates load-at-reload from load-at-once. Restart pulses show whether the phase counter realigns, through the count of oversample pulses up to the first mid-bit and bit enables. The synchronous runs drive the internal clock with both polarities, stop it with the run input, and toggle an external pin under both polarities. Together they separate the driven edge, the sampling edge and the pin direction.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam logic [1:0] PRE_DIV1  = 2'd0;
  localparam logic [1:0] PRE_DIV8  = 2'd1;
  localparam logic [1:0] PRE_DIV32 = 2'd2;

  localparam logic [1:0] HS_OFF = 2'd0;
  localparam logic [1:0] HS_CTS = 2'd1;
  localparam logic [1:0] HS_RTS = 2'd2;
endpackage

// File: rtl/sclk_brg.sv
module sclk_brg
  import sclk_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int PRE_LO_LOG = 3,
  parameter int PRE_HI_LOG = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       presc_sel_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [PRE_HI_LOG-1:0] pre_q;
  logic [1:0]            sel_q;
  logic [DIV_W-1:0]      cnt_q;
  logic                  pre_tick;

  always_comb begin
    case (sel_q)
      PRE_DIV1: pre_tick = 1'b1;
      PRE_DIV8: pre_tick = &pre_q[PRE_LO_LOG-1:0];
      default:  pre_tick = &pre_q;
    endcase
  end

  assign tick_o = pre_tick && (cnt_q == '0) && !restart_i;

  // settings are latched only at reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sel_q <= PRE_DIV1;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (restart_i) begin
        cnt_q <= divisor_i;
        sel_q <= presc_sel_i;
      end else if (pre_tick) begin
        if (cnt_q == '0) begin
          cnt_q <= divisor_i;
          sel_q <= presc_sel_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sclk_async.sv
module sclk_async #(
  parameter int OS_RATE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic restart_i,
  output logic os_o,
  output logic tx_o,
  output logic rx_o
);
  localparam int OS_W = $clog2(OS_RATE);
  localparam logic [OS_W-1:0] PH_LAST = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] PH_MID  = OS_W'(OS_RATE / 2 - 1);

  logic [OS_W-1:0] ph_q;
  logic            hit;

  assign hit = tick_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      os_o <= 1'b0;
      tx_o <= 1'b0;
      rx_o <= 1'b0;
    end else begin
      if (restart_i)  ph_q <= '0;
      else if (hit)   ph_q <= ph_q + 1'b1;
      os_o <= hit;
      tx_o <= hit && (ph_q == PH_LAST);
      rx_o <= hit && (ph_q == PH_MID);
    end
  end
endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic int_en_i,
  input  logic ext_en_i,
  input  logic run_i,
  input  logic inv_i,
  input  logic pin_i,
  output logic pin_o,
  output logic tx_o,
  output logic rx_o
);
  logic                   lvl_q;
  logic [SYNC_STAGES-1:0] sy_q;
  logic                   prev_q;
  logic                   raw;
  logic                   int_rise, int_fall, ext_rise, ext_fall;

  assign raw      = sy_q[SYNC_STAGES-1] ^ inv_i;
  assign int_rise = int_en_i && tick_i && run_i && !lvl_q;
  assign int_fall = int_en_i && tick_i && lvl_q;
  assign ext_rise = ext_en_i && raw && !prev_q;
  assign ext_fall = ext_en_i && !raw && prev_q;
  assign pin_o    = lvl_q ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      sy_q   <= '0;
      prev_q <= 1'b0;
      tx_o   <= 1'b0;
      rx_o   <= 1'b0;
    end else begin
      sy_q   <= {sy_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= raw;
      if (!int_en_i)                lvl_q <= 1'b0;
      else if (int_rise || int_fall) lvl_q <= !lvl_q;
      tx_o <= int_fall || ext_fall;
      rx_o <= int_rise || ext_rise;
    end
  end
endmodule

// File: rtl/sclk_hshake.sv
module sclk_hshake
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pin_i,
  input  logic       rx_ready_i,
  output logic       cts_ok_o,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic [SYNC_STAGES-1:0] sy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sy_q <= '1;
    else         sy_q <= {sy_q[SYNC_STAGES-2:0], pin_i};
  end

  assign cts_ok_o = (mode_i == HS_CTS) ? !sy_q[SYNC_STAGES-1] : 1'b1;
  assign pin_oe_o = (mode_i == HS_RTS);
  assign pin_o    = (mode_i == HS_RTS) ? !rx_ready_i : 1'b1;
endmodule

// File: rtl/serial_clk_gen.sv
module serial_clk_gen #(
  parameter int DIV_W       = 8,
  parameter int PRE_LO_LOG  = 3,
  parameter int PRE_HI_LOG  = 5,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       presc_sel_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             sync_mode_i,
  input  logic             ext_clk_i,
  input  logic             clk_inv_i,
  input  logic             sync_run_i,
  input  logic             restart_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  input  logic [1:0]       hs_mode_i,
  input  logic             hs_i,
  input  logic             rx_ready_i,
  output logic             hs_o,
  output logic             hs_oe_o,
  output logic             cts_ok_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             os_en_o
);
  logic tick, int_en, ext_en;
  logic a_tx, a_rx, s_tx, s_rx;

  assign int_en = sync_mode_i && !ext_clk_i;
  assign ext_en = sync_mode_i && ext_clk_i;

  sclk_brg #(.DIV_W(DIV_W), .PRE_LO_LOG(PRE_LO_LOG), .PRE_HI_LOG(PRE_HI_LOG)) i_brg (
    .clk_i, .rst_ni, .presc_sel_i, .divisor_i, .restart_i, .tick_o(tick)
  );

  sclk_async #(.OS_RATE(OS_RATE)) i_async (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(!sync_mode_i), .restart_i,
    .os_o(os_en_o), .tx_o(a_tx), .rx_o(a_rx)
  );

  sclk_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .tick_i(tick), .int_en_i(int_en), .ext_en_i(ext_en),
    .run_i(sync_run_i), .inv_i(clk_inv_i), .pin_i(sclk_i), .pin_o(sclk_o),
    .tx_o(s_tx), .rx_o(s_rx)
  );

  sclk_hshake #(.SYNC_STAGES(SYNC_STAGES)) i_hs (
    .clk_i, .rst_ni, .mode_i(hs_mode_i), .pin_i(hs_i), .rx_ready_i,
    .cts_ok_o, .pin_o(hs_o), .pin_oe_o(hs_oe_o)
  );

  assign sclk_oe_o = int_en;
  assign tx_en_o   = a_tx || s_tx;
  assign rx_en_o   = a_rx || s_rx;
endmodule

// File: rtl/serial_clk_gen_chk.sv
module serial_clk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_mode_i,
  input logic       ext_clk_i,
  input logic       clk_inv_i,
  input logic       sync_run_i,
  input logic       restart_i,
  input logic [1:0] hs_mode_i,
  input logic       sclk_o,
  input logic       sclk_oe_o,
  input logic       cts_ok_o,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       os_en_o
);
  AST_EN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_en_o && rx_en_o)); // R5
  AST_OS_ASYNC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os_en_o |-> $past(!sync_mode_i)); // R9
  AST_TX_ON_OS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && $past(!sync_mode_i)) |-> os_en_o); // R1
  AST_RESTART_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !os_en_o); // R3
  AST_EXT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clk_i |-> !sclk_oe_o); // R8
  AST_CTS_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_i != 2'd1) |-> cts_ok_o); // R10
  AST_TX_AT_IDLE_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && sclk_oe_o && $past(sclk_oe_o) && $stable(clk_inv_i)) |-> (sclk_o == clk_inv_i)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_oe_o && $past(sclk_oe_o) && !$past(sync_run_i) && $stable(clk_inv_i)
     && ($past(sclk_o) == clk_inv_i)) |-> $stable(sclk_o)); // R6
endmodule

bind serial_clk_gen serial_clk_gen_chk i_chk (
  .clk_i, .rst_ni, .sync_mode_i, .ext_clk_i, .clk_inv_i, .sync_run_i, .restart_i,
  .hs_mode_i, .sclk_o, .sclk_oe_o, .cts_ok_o, .tx_en_o, .rx_en_o, .os_en_o
);

// File: tb/test_serial_clk_gen.sv
module test_serial_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic [7:0] divisor = 8'd0;
  logic       sync_mode = 1'b0, ext_clk = 1'b0, clk_inv = 1'b0, sync_run = 1'b1;
  logic       restart = 1'b0, sclk_in = 1'b0;
  logic [1:0] hs_mode = 2'd0;
  logic       hs_in = 1'b1, rx_ready = 1'b0;
  logic       sclk_out, sclk_oe, hs_out, hs_oe, cts_ok, tx_en, rx_en, os_en;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_clk_gen i_serial_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .presc_sel_i(presc_sel), .divisor_i(divisor),
    .sync_mode_i(sync_mode), .ext_clk_i(ext_clk), .clk_inv_i(clk_inv),
    .sync_run_i(sync_run), .restart_i(restart), .sclk_i(sclk_in),
    .sclk_o(sclk_out), .sclk_oe_o(sclk_oe), .hs_mode_i(hs_mode), .hs_i(hs_in),
    .rx_ready_i(rx_ready), .hs_o(hs_out), .hs_oe_o(hs_oe), .cts_ok_o(cts_ok),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .os_en_o(os_en)
  );

  function automatic int exp_os(input logic [1:0] sel, input int n);
    int m;
    m = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 8 : 32;
    return m * (n + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // which: 0 os, 1 tx, 2 rx; at = -1 on timeout
  task automatic wait_en(input int which, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which == 0 && os_en) || (which == 1 && tx_en) || (which == 2 && rx_en)) begin
        at = cyc;
        return;
      end
    end
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int t0, t1, t2, a, n, cnt_os, rx_at, tx_at, bad, ntx, nrx;
    logic [1:0] sel;
    void'($urandom(32'd4242));

    // R11 reset state
    idle(3);
    chk(!tx_en && !rx_en && !os_en, "R11 enables", {tx_en, rx_en, os_en}, 0);
    chk(!sclk_oe && sclk_out == clk_inv, "R11 pin", {sclk_oe, sclk_out}, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 / R2 random prescale and divisor
    for (int it = 0; it < 8; it++) begin
      sel = 2'($urandom_range(0, 3));
      n = $urandom_range(0, 7);
      presc_sel = sel; divisor = 8'(n);
      do_restart();
      wait_en(0, 4000, t0);
      wait_en(0, 4000, t1);
      wait_en(0, 4000, t2);
      chk(t2 - t1 == exp_os(sel, n), (sel == 0) ? "R1 os interval" : "R2 os interval",
          t2 - t1, exp_os(sel, n));
      if (sel == 2'd0) begin
        wait_en(1, 4000, t0);
        wait_en(1, 4000, t1);
        chk(t1 - t0 == 16 * (n + 1), "R1 tx interval", t1 - t0, 16 * (n + 1));
      end
    end
    // R2 directed large divisor at /32
    presc_sel = 2'd2; divisor = 8'd255;
    do_restart();
    wait_en(0, 20000, t0);
    wait_en(0, 20000, t1);
    chk(t1 - t0 == 32 * 256, "R2 div32 n255", t1 - t0, 32 * 256);

    // R3 restart alignment
    for (int k = 0; k < 2; k++) begin
      presc_sel = 2'd0; divisor = 8'(2 + k);
      idle(7 + k);
      do_restart();
      cnt_os = 0; rx_at = -1; tx_at = -1;
      for (int i = 0; i < 200 && tx_at < 0; i++) begin
        @(negedge clk);
        if (os_en) cnt_os++;
        if (rx_en && rx_at < 0) rx_at = cnt_os;
        if (tx_en && tx_at < 0) tx_at = cnt_os;
      end
      chk(rx_at == 8, "R3 first rx", rx_at, 8);
      chk(tx_at == 16, "R3 first tx", tx_at, 16);
    end

    // R4 write applies at next reload
    presc_sel = 2'd0; divisor = 8'd20;
    do_restart();
    wait_en(0, 100, t0);
    idle(3);
    divisor = 8'd3;
    wait_en(0, 100, t1);
    wait_en(0, 100, t2);
    chk(t1 - t0 == 21, "R4 old period kept", t1 - t0, 21);
    chk(t2 - t1 == 4, "R4 new period", t2 - t1, 4);

    // R9 async pin idle
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk_oe || sclk_out != clk_inv) bad++;
    end
    chk(bad == 0, "R9 async pin", bad, 0);

    // R5 / R7 internal sync clock, both polarities
    for (int p = 0; p < 2; p++) begin
      n = $urandom_range(1, 9);
      divisor = 8'(n); clk_inv = p[0]; sync_mode = 1'b1; ext_clk = 1'b0; sync_run = 1'b1;
      idle(4 * (n + 1));
      chk(sclk_oe == 1'b1, "R5 oe", sclk_oe, 1);
      wait_en(2, 200, t0);
      chk(sclk_out == !clk_inv, "R5 rx at active level", sclk_out, !clk_inv);
      wait_en(1, 200, t1);
      chk(sclk_out == clk_inv, "R7 tx at inactive level", sclk_out, clk_inv);
      chk(t1 - t0 == n + 1, "R5 half period", t1 - t0, n + 1);
      // R6 stop
      sync_run = 1'b0;
      idle(2 * (n + 1) + 4);
      bad = 0;
      for (int i = 0; i < 4 * (n + 1); i++) begin
        @(negedge clk);
        if (sclk_out != clk_inv || tx_en || rx_en) bad++;
      end
      chk(bad == 0, "R6 idle at inactive", bad, 0);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (os_en) bad++;
      end
      chk(bad == 0, "R9 no os in sync", bad, 0);
    end

    // R8 external clock
    sync_run = 1'b1; ext_clk = 1'b1; clk_inv = 1'b0; sclk_in = 1'b0; divisor = 8'd0;
    idle(10);
    chk(sclk_oe == 1'b0, "R8 no drive", sclk_oe, 0);
    a = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_en || rx_en) a++;
    end
    chk(a == 0, "R8 static pin", a, 0);
    for (int e = 0; e < 3; e++) begin
      if (e == 2) begin clk_inv = 1'b1; idle(10); end
      sclk_in = !sclk_in;
      ntx = 0; nrx = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (tx_en) ntx++;
        if (rx_en) nrx++;
      end
      // e0: rise, inv0 -> rx; e1: fall -> tx; e2: rise, inv1 -> tx
      if (e == 0) chk(nrx == 1 && ntx == 0, "R8 rise gives rx", nrx * 10 + ntx, 10);
      if (e == 1) chk(nrx == 0 && ntx == 1, "R8 fall gives tx", nrx * 10 + ntx, 1);
      if (e == 2) chk(nrx == 0 && ntx == 1, "R7 inverted rise gives tx", nrx * 10 + ntx, 1);
    end
    clk_inv = 1'b0; ext_clk = 1'b0; sync_mode = 1'b0;

    // R10 handshake
    hs_mode = 2'd0; hs_in = 1'b1; idle(4);
    chk(cts_ok && !hs_oe, "R10 disabled", {cts_ok, hs_oe}, 2);
    hs_mode = 2'd3; idle(2);
    chk(cts_ok && !hs_oe, "R10 mode3 disabled", {cts_ok, hs_oe}, 2);
    hs_mode = 2'd1; hs_in = 1'b0; idle(4);
    chk(cts_ok == 1'b1, "R10 cts low permits", cts_ok, 1);
    hs_in = 1'b1; idle(4);
    chk(cts_ok == 1'b0, "R10 cts high blocks", cts_ok, 0);
    hs_mode = 2'd2; rx_ready = 1'b1; idle(2);
    chk(hs_oe && !hs_out && cts_ok, "R10 rts ready", {hs_oe, hs_out, cts_ok}, 5);
    rx_ready = 1'b0; idle(2);
    chk(hs_oe && hs_out, "R10 rts not ready", {hs_oe, hs_out}, 3);

    done = 1'b1;
    finish_run();
  end
endmodule